// File: doc/BRIEF.md
# Geometry Matrix Stack Controller

This block keeps the stack bookkeeping for the matrices of a fixed-function geometry front end. It accepts one decoded command at a time, each with a small parameter. The commands are: choose the target stack, push, pop by a signed count, store to an absolute slot, and restore from an absolute slot. It holds three stacks. A projection stack and a texture stack each have a single entry. A 32-entry stack is shared by the position and direction matrices, and both move under one common pointer.

The matrices themselves live elsewhere. A matrix storage RAM holds sixteen words per entry, and the current-matrix registers sit outside this block. The controller only sequences the copy between them, one word per cycle. It drives a word address made of a region code, a slot and a word index, together with a write enable (current matrix into storage) or a read enable (storage into current matrix). It also exposes the two pointers, the selected mode, a busy flag and a sticky stack error flag. The arithmetic of matrix loads and multiplies is outside this block.

Top module: `mstk_ctrl`

## Requirements
- R1: After reset the shared pointer and the projection pointer read 0, the selected mode is 0, the error flag is 0, busy is 0 and neither memory enable is high.
- R2: A command is taken when `cmd_valid` is high and busy is low. The `cmd_op` codes are: 1 select mode (`cmd_arg[1:0]`), 2 push, 3 pop, 4 store, 5 restore. Codes 0, 6 and 7 do nothing. Mode 0 targets projection, modes 1 and 2 both target the shared stack, and mode 3 targets texture. A mode select starts no copy.
- R3: A push on the shared stack writes slot = pointer, first into region 1 (position) and then into region 2 (direction), and then adds 1 to the pointer. A push taken while the pointer is 31 sets the error flag, and the pointer wraps to 0.
- R4: A pop on the shared stack subtracts the 6-bit two's-complement `cmd_arg` from the pointer and reads both regions at the new pointer value. If the true result lies outside 0..31, the error flag is set and the pointer keeps the result modulo 32.
- R5: Store (write) and restore (read) on the shared stack use slot `cmd_arg[4:0]` and leave both pointers unchanged. Slot 31 sets the error flag.
- R6: On the projection stack (region 0) every copy uses slot 0, and the parameter is ignored. A push moves the 1-bit pointer from 0 to 1 and flags an error when the pointer is already 1. A pop always steps the pointer down by 1 and flags an error when the pointer is 0. The pointer wraps in both cases. Store and restore never flag an error.
- R7: On the texture stack (region 3) every copy uses slot 0, no pointer moves and no error is raised.
- R8: The memory address is {region[1:0], slot[4:0], word[3:0]}. Busy rises in the cycle after a copy command is taken. It stays high for exactly 16 cycles per matrix copied, which is 32 on the shared stack and 16 otherwise. The word index runs 0 to 15 for each matrix. `mem_we` is high throughout push and store, and `mem_re` is high throughout pop and restore. Commands presented while busy is high have no effect.
- R9: The error flag stays set until `err_ack` is taken. If a new error and `err_ack` arrive in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_op | input | 3 | Command code |
| cmd_arg | input | 6 | Command parameter (mode, signed pop count or slot) |
| err_ack | input | 1 | Clears the sticky error flag |
| busy | output | 1 | A matrix copy is in progress; commands are not taken |
| mem_we | output | 1 | Storage write (current matrix into stack slot) |
| mem_re | output | 1 | Storage read (stack slot into current matrix) |
| mem_addr | output | 11 | {region, slot, word} address of the word being copied |
| cur_mode | output | 2 | Selected stack mode |
| pd_ptr | output | 5 | Shared position/direction stack pointer |
| proj_ptr | output | 1 | Projection stack pointer |
| stk_err | output | 1 | Sticky stack overflow/underflow/offset error |

## Verification
A wrong pointer shows on `pd_ptr` or `proj_ptr` in the cycle after the command is taken. It shows again in the slot field of `mem_addr` on the next push or pop, so one bad step spoils every later copy address. A miscounted copy shows as a busy window that is not 16 or 32 cycles long, or as a word index that does not start at 0. A lost error, or an acknowledge that wins over a new error, shows directly on `stk_err` one cycle after the offending command. A command that slips through while busy shows as an extra pointer step or a mode change once busy falls.

// File: rtl/mstk_pkg.sv
package mstk_pkg;

   typedef enum logic [2:0] {
      OP_NOP     = 3'd0,
      OP_MODE    = 3'd1,
      OP_PUSH    = 3'd2,
      OP_POP     = 3'd3,
      OP_STORE   = 3'd4,
      OP_RESTORE = 3'd5
   } mstk_op_e;

   localparam logic [1:0] RG_PROJ = 2'd0;
   localparam logic [1:0] RG_POS  = 2'd1;
   localparam logic [1:0] RG_DIR  = 2'd2;
   localparam logic [1:0] RG_TEX  = 2'd3;

endpackage

// File: rtl/mstk_ptr.sv
// Stack pointer with signed pop step; faults when the step leaves 0..2^PW-1.
module mstk_ptr #(
   parameter int PW = 5,
   parameter int CW = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 push_i,
   input  logic                 pop_i,
   input  logic signed [CW-1:0] cnt_i,
   output logic [PW-1:0]        ptr_o,
   output logic                 fault_o
);
   localparam int XW = ((PW > CW) ? PW : CW) + 2;

   logic signed [XW-1:0] base, step, diff;
   logic                 out_of_range;

   assign base = $signed({{(XW-PW){1'b0}}, ptr_o});
   assign step = $signed({{(XW-CW){cnt_i[CW-1]}}, cnt_i});
   assign diff = base - step;
   assign out_of_range = (diff[XW-1:PW] != '0);
   assign fault_o = (push_i & (&ptr_o)) | (pop_i & out_of_range);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_o <= '0;
      else if (push_i) ptr_o <= ptr_o + 1'b1;
      else if (pop_i)  ptr_o <= diff[PW-1:0];
   end

   AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_i && pop_i)); // R2
endmodule

// File: rtl/mstk_copy.sv
// Word-by-word copy sequencer; one or two matrices per command.
module mstk_copy
   import mstk_pkg::*;
#(
   parameter int SLOT_W = 5,
   parameter int WORD_W = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic                       pair_i,
   input  logic                       wr_i,
   input  logic [1:0]                 region_i,
   input  logic [SLOT_W-1:0]          slot_i,
   output logic                       busy_o,
   output logic                       we_o,
   output logic                       re_o,
   output logic [2+SLOT_W+WORD_W-1:0] addr_o
);
   logic              pair_q, wr_q;
   logic [1:0]        rg_q, rg_eff;
   logic [SLOT_W-1:0] slot_q;
   logic [WORD_W:0]   cnt;
   logic              last;

   assign last   = (&cnt[WORD_W-1:0]) && (cnt[WORD_W] == pair_q);
   assign rg_eff = pair_q ? (cnt[WORD_W] ? RG_DIR : RG_POS) : rg_q;
   assign we_o   = busy_o & wr_q;
   assign re_o   = busy_o & ~wr_q;
   assign addr_o = {rg_eff, slot_q, cnt[WORD_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         pair_q <= 1'b0;
         wr_q   <= 1'b0;
         rg_q   <= RG_PROJ;
         slot_q <= '0;
         cnt    <= '0;
      end else if (busy_o) begin
         if (last) begin
            busy_o <= 1'b0;
            cnt    <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else if (start_i) begin
         busy_o <= 1'b1;
         pair_q <= pair_i;
         wr_q   <= wr_i;
         rg_q   <= region_i;
         slot_q <= slot_i;
         cnt    <= '0;
      end
   end

   AST_WORD_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (addr_o[WORD_W-1:0] == '0)); // R8
   AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !(&addr_o[WORD_W-1:0])) |=> busy_o); // R8
endmodule

// File: rtl/mstk_ctrl.sv
module mstk_ctrl
   import mstk_pkg::*;
#(
   parameter int SLOT_W = 5,
   parameter int WORDS  = 16,
   parameter int CNT_W  = 6
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  cmd_valid,
   input  logic [2:0]                            cmd_op,
   input  logic [CNT_W-1:0]                      cmd_arg,
   input  logic                                  err_ack,
   output logic                                  busy,
   output logic                                  mem_we,
   output logic                                  mem_re,
   output logic [2+SLOT_W+$clog2(WORDS)-1:0]     mem_addr,
   output logic [1:0]                            cur_mode,
   output logic [SLOT_W-1:0]                     pd_ptr,
   output logic                                  proj_ptr,
   output logic                                  stk_err
);
   localparam int WORD_W = $clog2(WORDS);

   generate
      if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
         $error("WORDS must be a power of two of at least 2");
      end
      if (CNT_W <= SLOT_W) begin : g_bad_cnt
         $error("CNT_W must exceed SLOT_W");
      end
   endgenerate

   mstk_op_e          op;
   logic              accept, shared, is_proj;
   logic              do_push, do_pop, do_mem, do_copy, wr;
   logic              pd_push, pd_pop, pd_fault;
   logic              pj_push, pj_pop, pj_fault;
   logic              off_fault, err_set;
   logic [SLOT_W-1:0] slot, off, pop_tgt;
   logic [1:0]        region;

   assign op      = mstk_op_e'(cmd_op);
   assign accept  = cmd_valid & ~busy;
   assign shared  = (cur_mode == 2'd1) || (cur_mode == 2'd2);
   assign is_proj = (cur_mode == 2'd0);
   assign off     = cmd_arg[SLOT_W-1:0];

   assign do_push = accept && (op == OP_PUSH);
   assign do_pop  = accept && (op == OP_POP);
   assign do_mem  = accept && ((op == OP_STORE) || (op == OP_RESTORE));
   assign do_copy = do_push | do_pop | do_mem;
   assign wr      = (op == OP_PUSH) || (op == OP_STORE);

   assign pd_push = do_push & shared;
   assign pd_pop  = do_pop  & shared;
   assign pj_push = do_push & is_proj;
   assign pj_pop  = do_pop  & is_proj;

   mstk_ptr #(.PW(SLOT_W), .CW(CNT_W)) u_pd_ptr (
      .clk(clk), .rst_n(rst_n), .push_i(pd_push), .pop_i(pd_pop),
      .cnt_i($signed(cmd_arg)), .ptr_o(pd_ptr), .fault_o(pd_fault));

   mstk_ptr #(.PW(1), .CW(2)) u_pj_ptr (
      .clk(clk), .rst_n(rst_n), .push_i(pj_push), .pop_i(pj_pop),
      .cnt_i(2'sb01), .ptr_o(proj_ptr), .fault_o(pj_fault));

   assign pop_tgt   = pd_ptr - off;
   assign off_fault = do_mem & shared & (&off);
   assign err_set   = pd_fault | pj_fault | off_fault;

   always_comb begin
      region = is_proj ? RG_PROJ : RG_TEX;
      slot   = '0;
      if (shared) begin
         region = RG_POS;
         if (op == OP_PUSH)     slot = pd_ptr;
         else if (op == OP_POP) slot = pop_tgt;
         else                   slot = off;
      end
   end

   mstk_copy #(.SLOT_W(SLOT_W), .WORD_W(WORD_W)) u_copy (
      .clk(clk), .rst_n(rst_n), .start_i(do_copy), .pair_i(shared),
      .wr_i(wr), .region_i(region), .slot_i(slot), .busy_o(busy),
      .we_o(mem_we), .re_o(mem_re), .addr_o(mem_addr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_mode <= 2'd0;
         stk_err  <= 1'b0;
      end else begin
         if (accept && op == OP_MODE) cur_mode <= cmd_arg[1:0];
         if (err_set)      stk_err <= 1'b1;
         else if (err_ack) stk_err <= 1'b0;
      end
   end

   AST_BUSY_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(pd_ptr) && $stable(proj_ptr) && $stable(cur_mode))); // R8
   AST_SLOT_OPS_KEEP_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      do_mem |=> ($stable(pd_ptr) && $stable(proj_ptr))); // R5
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_err && !err_ack) |=> stk_err); // R9
   AST_TEX_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cur_mode == 2'd3 && !stk_err) |=> !stk_err); // R7
   AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_we && !mem_re)); // R8
endmodule

// File: tb/mstk_ctrl_bench.sv
module mstk_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic [5:0]  cmd_arg = 6'd0;
   logic        err_ack = 1'b0;
   logic        busy, mem_we, mem_re, proj_ptr, stk_err;
   logic [10:0] mem_addr;
   logic [1:0]  cur_mode;
   logic [4:0]  pd_ptr;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   mstk_ctrl u_mstk_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_arg(cmd_arg), .err_ack(err_ack), .busy(busy), .mem_we(mem_we),
      .mem_re(mem_re), .mem_addr(mem_addr), .cur_mode(cur_mode),
      .pd_ptr(pd_ptr), .proj_ptr(proj_ptr), .stk_err(stk_err));

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   typedef struct packed {
      logic [2:0] op;  logic [5:0] arg; logic ack; logic [1:0] md;
      logic [4:0] pd;  logic pj; logic er; logic [5:0] cyc;
      logic wr; logic [1:0] rg; logic [4:0] sl;
   } vec_t;

   localparam int NV = 32;
   // fields: op arg ack | mode pd pj err | cycles wr region slot
   localparam vec_t VEC [NV] = '{
      '{3'd1,6'd1, 1'b0, 2'd1,5'd0, 1'b0,1'b0, 6'd0, 1'b0,2'd0,5'd0},   // R2 mode 1
      '{3'd2,6'd0, 1'b0, 2'd1,5'd1, 1'b0,1'b0, 6'd32,1'b1,2'd1,5'd0},   // R3 push
      '{3'd2,6'd0, 1'b0, 2'd1,5'd2, 1'b0,1'b0, 6'd32,1'b1,2'd1,5'd1},   // R3 push
      '{3'd3,6'd2, 1'b0, 2'd1,5'd0, 1'b0,1'b0, 6'd32,1'b0,2'd1,5'd0},   // R4 pop 2
      '{3'd4,6'd7, 1'b0, 2'd1,5'd0, 1'b0,1'b0, 6'd32,1'b1,2'd1,5'd7},   // R5 store 7
      '{3'd5,6'd31,1'b0, 2'd1,5'd0, 1'b0,1'b1, 6'd32,1'b0,2'd1,5'd31},  // R5 restore 31
      '{3'd0,6'd0, 1'b1, 2'd1,5'd0, 1'b0,1'b0, 6'd0, 1'b0,2'd0,5'd0},   // R9 ack
      '{3'd3,6'd1, 1'b0, 2'd1,5'd31,1'b0,1'b1, 6'd32,1'b0,2'd1,5'd31},  // R4 underflow
      '{3'd0,6'd0, 1'b1, 2'd1,5'd31,1'b0,1'b0, 6'd0, 1'b0,2'd0,5'd0},   // R9 ack
      '{3'd3,6'h3F,1'b0, 2'd1,5'd0, 1'b0,1'b1, 6'd32,1'b0,2'd1,5'd0},   // R4 pop -1 over
      '{3'd5,6'd31,1'b1, 2'd1,5'd0, 1'b0,1'b1, 6'd32,1'b0,2'd1,5'd31},  // R9 set wins
      '{3'd0,6'd0, 1'b1, 2'd1,5'd0, 1'b0,1'b0, 6'd0, 1'b0,2'd0,5'd0},   // R9 ack
      '{3'd1,6'd2, 1'b0, 2'd2,5'd0, 1'b0,1'b0, 6'd0, 1'b0,2'd0,5'd0},   // R2 mode 2
      '{3'd2,6'd0, 1'b0, 2'd2,5'd1, 1'b0,1'b0, 6'd32,1'b1,2'd1,5'd0},   // R3 push mode 2
      '{3'd3,6'd2, 1'b0, 2'd2,5'd31,1'b0,1'b1, 6'd32,1'b0,2'd1,5'd31},  // R4 underflow
      '{3'd0,6'd0, 1'b1, 2'd2,5'd31,1'b0,1'b0, 6'd0, 1'b0,2'd0,5'd0},   // R9 ack
      '{3'd2,6'd0, 1'b0, 2'd2,5'd0, 1'b0,1'b1, 6'd32,1'b1,2'd1,5'd31},  // R3 push at 31
      '{3'd0,6'd0, 1'b1, 2'd2,5'd0, 1'b0,1'b0, 6'd0, 1'b0,2'd0,5'd0},   // R9 ack
      '{3'd3,6'h22,1'b0, 2'd2,5'd30,1'b0,1'b0, 6'd32,1'b0,2'd1,5'd30},  // R4 pop -30
      '{3'd1,6'd0, 1'b0, 2'd0,5'd30,1'b0,1'b0, 6'd0, 1'b0,2'd0,5'd0},   // R2 mode 0
      '{3'd2,6'd0, 1'b0, 2'd0,5'd30,1'b1,1'b0, 6'd16,1'b1,2'd0,5'd0},   // R6 push
      '{3'd2,6'd0, 1'b0, 2'd0,5'd30,1'b0,1'b1, 6'd16,1'b1,2'd0,5'd0},   // R6 overflow
      '{3'd0,6'd0, 1'b1, 2'd0,5'd30,1'b0,1'b0, 6'd0, 1'b0,2'd0,5'd0},   // R9 ack
      '{3'd3,6'd5, 1'b0, 2'd0,5'd30,1'b1,1'b1, 6'd16,1'b0,2'd0,5'd0},   // R6 underflow
      '{3'd0,6'd0, 1'b1, 2'd0,5'd30,1'b1,1'b0, 6'd0, 1'b0,2'd0,5'd0},   // R9 ack
      '{3'd3,6'd5, 1'b0, 2'd0,5'd30,1'b0,1'b0, 6'd16,1'b0,2'd0,5'd0},   // R6 pop count ignored
      '{3'd4,6'd31,1'b0, 2'd0,5'd30,1'b0,1'b0, 6'd16,1'b1,2'd0,5'd0},   // R6 offset ignored
      '{3'd5,6'd9, 1'b0, 2'd0,5'd30,1'b0,1'b0, 6'd16,1'b0,2'd0,5'd0},   // R6 restore slot 0
      '{3'd1,6'd3, 1'b0, 2'd3,5'd30,1'b0,1'b0, 6'd0, 1'b0,2'd0,5'd0},   // R2 mode 3
      '{3'd2,6'd0, 1'b0, 2'd3,5'd30,1'b0,1'b0, 6'd16,1'b1,2'd3,5'd0},   // R7 push
      '{3'd3,6'd1, 1'b0, 2'd3,5'd30,1'b0,1'b0, 6'd16,1'b0,2'd3,5'd0},   // R7 pop
      '{3'd5,6'd31,1'b0, 2'd3,5'd30,1'b0,1'b0, 6'd16,1'b0,2'd3,5'd0}    // R7 restore 31
   };

   initial begin
      #1000000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int cyc;
      bit seq_ok;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 busy", busy, 0);
      check("R1 mode", cur_mode, 0);
      check("R1 pd_ptr", pd_ptr, 0);
      check("R1 proj_ptr", proj_ptr, 0);
      check("R1 err", stk_err, 0);
      check("R1 enables", {mem_we, mem_re}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         cmd_valid = 1'b1;
         cmd_op    = VEC[i].op;
         cmd_arg   = VEC[i].arg;
         err_ack   = VEC[i].ack;
         @(negedge clk);
         cmd_valid = 1'b0;
         err_ack   = 1'b0;
         cyc = 0;
         seq_ok = 1'b1;
         while (busy && cyc < 40) begin
            if (cyc == 0) begin
               check($sformatf("R8 v%0d first addr", i), mem_addr,
                     {VEC[i].rg, VEC[i].sl, 4'd0});
               check($sformatf("R8 v%0d direction", i), {mem_we, mem_re},
                     VEC[i].wr ? 2 : 1);
            end
            if (mem_addr[3:0] != cyc[3:0]) seq_ok = 1'b0;
            if (cyc >= 16 && mem_addr[10:9] != 2'd2) seq_ok = 1'b0;
            cyc++;
            @(negedge clk);
         end
         check($sformatf("R8 v%0d busy cycles", i), cyc, VEC[i].cyc);
         check($sformatf("R8 v%0d word sequence", i), seq_ok, 1);
         check($sformatf("R2 v%0d mode", i), cur_mode, VEC[i].md);
         check($sformatf("R3 R4 v%0d pd_ptr", i), pd_ptr, VEC[i].pd);
         check($sformatf("R6 v%0d proj_ptr", i), proj_ptr, VEC[i].pj);
         check($sformatf("R9 v%0d err", i), stk_err, VEC[i].er);
      end

      // R8: commands during busy are ignored
      cmd_valid = 1'b1; cmd_op = 3'd1; cmd_arg = 6'd1;
      @(negedge clk);
      cmd_op = 3'd2; cmd_arg = 6'd0;
      @(negedge clk);
      cmd_op = 3'd1; cmd_arg = 6'd0;
      cyc = 0;
      while (busy && cyc < 40) begin
         cyc++;
         @(negedge clk);
         if (cyc == 1) begin cmd_op = 3'd2; end
         if (cyc == 2) cmd_valid = 1'b0;
      end
      cmd_valid = 1'b0;
      check("R8 busy ignore cycles", cyc, 32);
      check("R8 busy ignore pd_ptr", pd_ptr, 31);
      check("R8 busy ignore mode", cur_mode, 1);

      // R1: reset in the middle of a copy
      cmd_valid = 1'b1; cmd_op = 3'd2;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid reset busy", busy, 0);
      check("R1 mid reset pd_ptr", pd_ptr, 0);
      check("R1 mid reset err", stk_err, 0);
      check("R1 mid reset mode", cur_mode, 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule